// File: doc/BRIEF.md
# Zone-Clocked Three-Valued Majority Full Adder

This block models, one system clock at a time, a one-bit full adder built only from three-input majority votes and inverters. The adder is laid out across four clock zones. Each cell holds one of three values: logic 0, logic 1, or neutral. A phase sequencer, driven by the single system clock, steps every zone through a repeating cycle of four phases, in this order:

1. switch
2. hold
3. release
4. relax

Each zone runs one phase behind the zone before it. A zone computes only while it is in switch. During switch it reads the values of the zone just ahead of it, which is then in hold. Zone 0 is the exception: it reads the input pins.

Zone 0 captures A, B and carry-in. Zone 1 forms the carry, plus one intermediate vote. Zone 2 forms the sum. Zone 3 carries a phase but no cells. A result may be used only while its zone is in hold, and a flag for each output marks that window. Because the carry and the sum live in different zones, the carry flag leads the sum flag by one phase, which is TICKS_PER_PHASE system clocks.

Phase sequencer states and transitions:

- All zones leave reset in relax, and they are not yet started.
- On each phase tick, a started zone moves one step: switch to hold, hold to release, release to relax, and relax back to switch.
- Zone 0 starts on the first tick after reset. Zone k starts on the tick after zone k-1 has started.
- A zone that starts enters switch.

Top module: `zoned_majority_adder`

## Requirements
- R1: After reset, every zone is in relax, so `zone_phase` reads 8'hFF. Both valid flags are low and both result outputs are 0.
- R2: Each zone's phase is reported in `zone_phase[2k+1:2k]` with the codes switch=0, hold=1, release=2, relax=3. A zone lasts TICKS_PER_PHASE system clocks in each phase, and the only phase change allowed is to the next code modulo 4.
- R3: Zone 0 enters switch TICKS_PER_PHASE clocks after reset is released, and zone k enters switch one phase after zone k-1 does. Whenever zone k (k = 1 to 3) is in switch, zone k-1 is in hold.
- R4: While `carry_valid` is high, `carry_out` equals the majority of A, B and carry-in. The operands are those sampled in the last clock of zone 0's switch phase.
- R5: While `sum_valid` is high, `sum_out` equals MAJ(NOT carry, carry-in, MAJ(A, B, NOT carry-in)), which is A xor B xor carry-in for the same sampled operands.
- R6: `carry_valid` is high exactly while zone 1 is in hold, and `sum_valid` is high exactly while zone 2 is in hold. `sum_valid` rises TICKS_PER_PHASE clocks after `carry_valid` rises, on the same edge where `carry_valid` falls, and the two flags are never high together.
- R7: While its valid flag is low, each result output reads 0.
- R8: A zone in hold ignores its inputs. Input pin changes made after zone 0 has left switch change neither the held carry nor the sum that is derived from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 1 | Addend A |
| b_in | input | 1 | Addend B |
| c_in | input | 1 | Carry-in |
| sum_out | output | 1 | Sum bit, meaningful while sum_valid is high |
| sum_valid | output | 1 | High while the sum zone is in hold |
| carry_out | output | 1 | Carry-out bit, meaningful while carry_valid is high |
| carry_valid | output | 1 | High while the carry zone is in hold |
| zone_phase | output | 8 | Current phase of zones 0 to 3, two bits per zone |

## Verification
The bench walks the phase code through the startup staircase. A sequencer that started every zone at once, or that skipped relax, would show a wrong `zone_phase` word at one of the phase boundaries. All eight operand patterns are checked, and the sum is read only in its own window. A sum zone that read the carry zone while that zone was neutral, or a swapped inversion, would show up as a wrong sum on some pattern. The gap between the two flag rises is timed; an off-by-one zone lag would change it. A test flips the operands while the carry is held, and then expects the old carry and the old sum. A hold phase that kept recomputing would leak the new operands into the results.

// File: rtl/zma_pkg.sv
package zma_pkg;

    typedef enum logic [1:0] {
        PH_SWITCH  = 2'd0,
        PH_HOLD    = 2'd1,
        PH_RELEASE = 2'd2,
        PH_RELAX   = 2'd3
    } phase_t;

    // cell code: 00 neutral, 10 logic 0, 11 logic 1
    localparam logic [1:0] CELL_NEUTRAL = 2'b00;

    function automatic logic [1:0] cell_of(input logic b);
        return {1'b1, b};
    endfunction

    function automatic logic [1:0] cell_not(input logic [1:0] x);
        return x[1] ? {1'b1, ~x[0]} : CELL_NEUTRAL;
    endfunction

    function automatic logic [1:0] cell_maj(input logic [1:0] x,
                                            input logic [1:0] y,
                                            input logic [1:0] z);
        logic v;
        v = (x[0] & y[0]) | (x[0] & z[0]) | (y[0] & z[0]);
        return (x[1] & y[1] & z[1]) ? {1'b1, v} : CELL_NEUTRAL;
    endfunction

    function automatic phase_t phase_next(input phase_t p);
        phase_t n;
        unique case (p)
            PH_SWITCH:  n = PH_HOLD;
            PH_HOLD:    n = PH_RELEASE;
            PH_RELEASE: n = PH_RELAX;
            PH_RELAX:   n = PH_SWITCH;
            default:    n = PH_RELAX;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/zma_phase_seq.sv
module zma_phase_seq #(
    parameter int TICKS_PER_PHASE = 4,
    parameter int ZONES           = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [2*ZONES-1:0]   zone_phase
);
    import zma_pkg::*;

    localparam int CW = (TICKS_PER_PHASE > 1) ? $clog2(TICKS_PER_PHASE) : 1;

    logic [CW-1:0]    cnt;
    logic             tick;
    logic [ZONES-1:0] started;
    phase_t           ph [ZONES];

    assign tick = (cnt == CW'(TICKS_PER_PHASE - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    for (genvar k = 0; k < ZONES; k++) begin : g_zone
        logic ready;
        if (k == 0) begin : g_first
            assign ready = 1'b1;
        end else begin : g_rest
            assign ready = started[k-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                started[k] <= 1'b0;
                ph[k]      <= PH_RELAX;
            end else if (tick) begin
                if (started[k]) begin
                    ph[k] <= phase_next(ph[k]);
                end else if (ready) begin
                    started[k] <= 1'b1;
                    ph[k]      <= PH_SWITCH;
                end
            end
        end

        assign zone_phase[2*k +: 2] = ph[k];
    end

endmodule

// File: rtl/zma_zone.sv
module zma_zone #(
    parameter int CELLS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  zma_pkg::phase_t      phase,
    input  logic [2*CELLS-1:0]   eval,
    output logic [2*CELLS-1:0]   cells
);
    import zma_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else begin
            unique case (phase)
                PH_SWITCH:             cells <= eval;
                PH_HOLD:               cells <= cells;
                PH_RELEASE, PH_RELAX:  cells <= '0;
                default:               cells <= '0;
            endcase
        end
    end

endmodule

// File: rtl/zoned_majority_adder.sv
module zoned_majority_adder #(
    parameter int TICKS_PER_PHASE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a_in,
    input  logic       b_in,
    input  logic       c_in,
    output logic       sum_out,
    output logic       sum_valid,
    output logic       carry_out,
    output logic       carry_valid,
    output logic [7:0] zone_phase
);
    import zma_pkg::*;

    localparam int ZONES = 4;

    logic [5:0] z0_eval, z0_cells;   // {a, b, cin}
    logic [5:0] z1_eval, z1_cells;   // {carry, cin, inner vote}
    logic [1:0] z2_eval, z2_cells;   // {sum}

    zma_phase_seq #(
        .TICKS_PER_PHASE(TICKS_PER_PHASE),
        .ZONES          (ZONES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .zone_phase(zone_phase)
    );

    // zone 0: operand capture from the pins
    always_comb begin
        z0_eval = {cell_of(a_in), cell_of(b_in), cell_of(c_in)};
    end

    // zone 1: carry vote and inner vote with inverted carry-in
    always_comb begin
        z1_eval = {cell_maj(z0_cells[5:4], z0_cells[3:2], z0_cells[1:0]),
                   z0_cells[1:0],
                   cell_maj(z0_cells[5:4], z0_cells[3:2], cell_not(z0_cells[1:0]))};
    end

    // zone 2: sum vote with inverted carry
    always_comb begin
        z2_eval = cell_maj(cell_not(z1_cells[5:4]), z1_cells[3:2], z1_cells[1:0]);
    end

    zma_zone #(.CELLS(3)) u_z0 (
        .clk(clk), .rst_n(rst_n), .phase(phase_t'(zone_phase[1:0])),
        .eval(z0_eval), .cells(z0_cells));

    zma_zone #(.CELLS(3)) u_z1 (
        .clk(clk), .rst_n(rst_n), .phase(phase_t'(zone_phase[3:2])),
        .eval(z1_eval), .cells(z1_cells));

    zma_zone #(.CELLS(1)) u_z2 (
        .clk(clk), .rst_n(rst_n), .phase(phase_t'(zone_phase[5:4])),
        .eval(z2_eval), .cells(z2_cells));

    always_comb begin
        carry_valid = (phase_t'(zone_phase[3:2]) == PH_HOLD);
        sum_valid   = (phase_t'(zone_phase[5:4]) == PH_HOLD);
        carry_out   = carry_valid & z1_cells[5] & z1_cells[4];
        sum_out     = sum_valid & z2_cells[1] & z2_cells[0];
    end

endmodule

// File: rtl/zma_checker.sv
module zma_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sum_out,
    input logic       sum_valid,
    input logic       carry_out,
    input logic       carry_valid,
    input logic [7:0] zone_phase
);
    for (genvar k = 0; k < 4; k++) begin : g_ord
        AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(zone_phase[2*k +: 2]) |->
                zone_phase[2*k +: 2] == 2'($past(zone_phase[2*k +: 2]) + 2'd1)); // R2
    end

    for (genvar k = 1; k < 4; k++) begin : g_lag
        AST_SWITCH_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            zone_phase[2*k +: 2] == 2'd0 |-> zone_phase[2*(k-1) +: 2] == 2'd1); // R3
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_valid && sum_valid)); // R6

    AST_SUM_AFTER_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carry_valid) |-> sum_valid); // R6

    AST_CARRY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        carry_valid && $past(carry_valid) |-> $stable(carry_out)); // R8

    AST_SUM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid && $past(sum_valid) |-> $stable(sum_out)); // R8
endmodule

bind zoned_majority_adder zma_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sum_out    (sum_out),
    .sum_valid  (sum_valid),
    .carry_out  (carry_out),
    .carry_valid(carry_valid),
    .zone_phase (zone_phase)
);

// File: tb/zoned_majority_adder_test.sv
module zoned_majority_adder_test;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_in = 1'b0, b_in = 1'b0, c_in = 1'b0;
    logic sum_out, sum_valid, carry_out, carry_valid;
    logic [7:0] zone_phase;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    zoned_majority_adder #(.TICKS_PER_PHASE(N)) uut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .sum_out(sum_out), .sum_valid(sum_valid),
        .carry_out(carry_out), .carry_valid(carry_valid),
        .zone_phase(zone_phase));

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise_carry();
        int g = 0;
        while (carry_valid && g < 200) begin step(1); g++; end
        while (!carry_valid && g < 200) begin step(1); g++; end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1 zone_phase", zone_phase, 8'hFF);
        chk("R1 valids", {carry_valid, sum_valid}, 0);
        chk("R1 outputs", {carry_out, sum_out}, 0);
    endtask

    // reset released at a negedge; ticks land every N posedges after it
    task automatic t_phase_walk();
        rst_n = 1'b1;
        step(N - 1);
        chk("R3 before first tick", zone_phase, 8'hFF);
        step(1);
        chk("R3 zone0 switch", zone_phase, 8'hFC);
        step(N - 1);
        chk("R2 switch lasts N", zone_phase, 8'hFC);
        step(1);
        chk("R2 R3 step2", zone_phase, 8'hF1);
        step(N);
        chk("R2 R3 step3", zone_phase, 8'hC6);
        chk("R6 carry_valid in zone1 hold", carry_valid, 1);
        step(N);
        chk("R2 R3 step4", zone_phase, 8'h1B);
        chk("R6 sum_valid in zone2 hold", sum_valid, 1);
        chk("R6 carry_valid off", carry_valid, 0);
        step(N);
        chk("R2 wrap to switch", zone_phase, 8'h6C);
    endtask

    task automatic t_combo(input logic a, input logic b, input logic c);
        int gap = 0;
        a_in = a; b_in = b; c_in = c;
        step(8 * N);
        while (carry_valid) step(1);
        chk("R7 carry low when invalid", carry_out, 0);
        wait_rise_carry();
        chk("R4 carry", carry_out, (a & b) | (a & c) | (b & c));
        while (!sum_valid && gap < 100) begin step(1); gap++; end
        chk("R6 sum lag", gap, N);
        chk("R6 carry_valid dropped", carry_valid, 0);
        chk("R7 carry low after hold", carry_out, 0);
        chk("R5 sum", sum_out, a ^ b ^ c);
    endtask

    task automatic t_hold_freeze();
        int gap = 0;
        a_in = 1; b_in = 1; c_in = 0;
        step(8 * N);
        wait_rise_carry();
        a_in = 0; b_in = 0; c_in = 1;
        for (int i = 0; i < N - 1; i++) begin
            chk("R8 carry frozen", carry_out, 1);
            step(1);
        end
        chk("R8 carry still valid", carry_valid, 1);
        while (!sum_valid && gap < 100) begin step(1); gap++; end
        chk("R8 sum from old operands", sum_out, 0);
    endtask

    initial begin
        step(1);
        t_reset();
        t_phase_walk();
        for (int v = 0; v < 8; v++) t_combo(v[2], v[1], v[0]);
        t_hold_freeze();
        t_combo(1, 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired got=%0d expected=0", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule